// File: doc/BRIEF.md
# Command Ring Fetch Engine

This engine drains a command ring that software has placed in memory. Software first loads the ring control register with the ring's base address and its expected cycle bit. It then rings the command doorbell. The engine reads 16-byte command descriptors one at a time. It uses the cycle bit in each descriptor as the ownership marker: a descriptor belongs to the engine only while that bit matches the expected one. The engine stops at the first descriptor it does not own.

For each descriptor it consumes, the engine hands one success completion event to an event producer through a valid/ready handshake. Link descriptors redirect the fetch pointer to another part of memory, and they may flip the expected cycle bit. When the ring stops on an ownership mismatch, the stop position is written back into the control register and the running flag is cleared. The commands themselves are not carried out here. This block only sequences the fetches and reports completions.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After `rst_n` is low, `ctl_q` is 0, and `busy`, `mem_req` and `evt_valid` are 0.
- R2: A `db_ring` pulse while idle sets `ctl_q` bit 3 (running). It also starts the first read at `ctl_q` with bits 5:0 cleared. While `busy` is high, bit 3 stays set.
- R3: A `db_ring` pulse while `busy` is high is ignored: no extra read is issued.
- R4: A read response carries the descriptor on `mem_rdata`. Bits 63:0 hold the pointer, bits 95:64 the status and bits 127:96 the control word. Control bit 0 is the cycle bit, bit 1 is the toggle flag, bits 15:10 are the type and bits 31:22 are the target interrupter. Every read address is a multiple of 16.
- R5: When the cycle bit differs from `ctl_q` bit 0, the engine goes idle and raises no event. `ctl_q` becomes the read address with bits 5:0 replaced by the previous `ctl_q` bits 5:0, and bit 3 is cleared.
- R6: Each descriptor the engine owns produces exactly one event, in ring order, before the next read is issued. In that event, `evt_ptr` is the descriptor address, `evt_status` is 0x01000000, `evt_control` is 0x00008401 (type 33, cycle bit set) and `evt_intr` is control bits 31:22.
- R7: While `evt_valid` is high and `evt_ready` is low, `evt_valid`, `evt_ptr` and `evt_intr` hold their values.
- R8: After an owned descriptor of type 6 (link) is accepted, the next read goes to its pointer with bits 5:0 cleared. After any other type, the next read goes to the address plus 16.
- R9: An accepted link descriptor whose toggle flag is set inverts `ctl_q` bit 0. Descriptors read after it are checked against the new value.
- R10: A response with `mem_err` high makes the engine go idle with no event and leaves `ctl_q` unchanged.
- R11: A `ctl_clear` pulse aborts any activity and sets `ctl_q` to 0.
- R12: `ctl_wr` loads `ctl_q` from `ctl_wdata` only while idle, and it wins over a `db_ring` in the same cycle. While `busy` is high, `ctl_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_clear | input | 1 | Controller reset: clears the control register and aborts |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | ADDR_W | Control register write value |
| ctl_q | output | ADDR_W | Control register: ring pointer, bit 3 running, bit 0 cycle |
| db_ring | input | 1 | Command doorbell pulse |
| busy | output | 1 | Engine is fetching or emitting |
| mem_req | output | 1 | Read request, held until a response arrives |
| mem_addr | output | ADDR_W | Descriptor address |
| mem_valid | input | 1 | Read response strobe |
| mem_err | input | 1 | Read failed, qualified by `mem_valid` |
| mem_rdata | input | 128 | Descriptor contents |
| evt_valid | output | 1 | Completion event available |
| evt_ready | input | 1 | Event producer accepts |
| evt_ptr | output | ADDR_W | Address of the completed descriptor |
| evt_status | output | 32 | Completion status word |
| evt_control | output | 32 | Completion control word |
| evt_intr | output | 10 | Target interrupter |

## Verification
The bench builds the engine with `ADDR_W` set to 32. This keeps the addresses readable while leaving room for link targets far from the ring base. It also puts the stop-position write-back of bits 31:6 within a compact model. A behavioural model walks the same memory image to predict the sequence of read addresses, the sequence of events and the final control word. The image includes link jumps with and without the cycle toggle, unaligned link pointers and injected read errors. The event sink applies backpressure in some runs, so each event must wait for `evt_ready` and stay stable until then. Doorbell and control writes arrive mid-run to confirm that both are ignored while busy.

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_clear,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_wdata,
  output logic [ADDR_W-1:0] ctl_q,
  input  logic              db_ring,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic              mem_err,
  input  logic [127:0]      mem_rdata,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [ADDR_W-1:0] evt_ptr,
  output logic [31:0]       evt_status,
  output logic [31:0]       evt_control,
  output logic [9:0]        evt_intr
);

  localparam int          CYC_B   = 0;
  localparam int          RUN_B   = 3;
  localparam logic [5:0]  T_LINK  = 6'd6;
  localparam logic [5:0]  T_DONE  = 6'd33;
  localparam logic [7:0]  CC_OK   = 8'd1;
  localparam int          STEP    = 16;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT} state_t;

  state_t              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ADDR_W-1:0]   jump_q;
  logic                link_q;
  logic                flip_q;

  logic [31:0]         trb_ctl;
  logic [ADDR_W-1:0]   trb_ptr;
  logic                owned;
  logic                unused_ok;

  assign trb_ctl   = mem_rdata[127:96];
  assign trb_ptr   = mem_rdata[ADDR_W-1:0];
  assign owned     = trb_ctl[0] == ctl_q[CYC_B];
  assign unused_ok = ^mem_rdata;

  assign busy        = state_q != S_IDLE;
  assign mem_req     = state_q == S_FETCH;
  assign mem_addr    = addr_q;
  assign evt_valid   = state_q == S_EMIT;
  assign evt_status  = {CC_OK, 24'd0};
  assign evt_control = {16'd0, T_DONE, 9'd0, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_clear) begin
      state_q  <= S_IDLE;
      ctl_q    <= '0;
      addr_q   <= '0;
      jump_q   <= '0;
      link_q   <= 1'b0;
      flip_q   <= 1'b0;
      evt_ptr  <= '0;
      evt_intr <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (ctl_wr) begin
            ctl_q <= ctl_wdata;
          end else if (db_ring) begin
            ctl_q[RUN_B] <= 1'b1;
            addr_q       <= {ctl_q[ADDR_W-1:6], 6'd0};
            state_q      <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_valid) begin
            if (mem_err) begin
              state_q <= S_IDLE;
            end else if (!owned) begin
              ctl_q   <= {addr_q[ADDR_W-1:6], ctl_q[5:4], 1'b0, ctl_q[2:0]};
              state_q <= S_IDLE;
            end else begin
              evt_ptr  <= addr_q;
              evt_intr <= trb_ctl[31:22];
              link_q   <= trb_ctl[15:10] == T_LINK;
              flip_q   <= trb_ctl[1];
              jump_q   <= {trb_ptr[ADDR_W-1:6], 6'd0};
              state_q  <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          if (evt_ready) begin
            if (link_q) begin
              addr_q       <= jump_q;
              ctl_q[CYC_B] <= ctl_q[CYC_B] ^ flip_q;
            end else begin
              addr_q <= addr_q + ADDR_W'(STEP);
            end
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !evt_valid);

  a_r2_running_flag: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ctl_q[RUN_B]);

  a_r4_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[3:0] == 4'd0);

  a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(mem_err) && !$past(ctl_clear) |-> !ctl_q[RUN_B]);

  a_r6_event_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> $past(mem_valid && !mem_err));

  a_r7_event_hold: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready && !ctl_clear |=> evt_valid && $stable(evt_ptr) && $stable(evt_intr));

  a_r12_wr_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_wr && !ctl_clear && !mem_valid && !evt_ready |=> $stable(ctl_q));

endmodule

// File: tb/cmd_ring_fetch_tb_top.sv
`timescale 1ns/1ps
module cmd_ring_fetch_tb_top;
  localparam int AW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic ctl_clear = 0, ctl_wr = 0, db_ring = 0;
  logic [AW-1:0] ctl_wdata = '0;
  logic [AW-1:0] ctl_q;
  logic busy, mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_valid = 0, mem_err = 0;
  logic [127:0] mem_rdata = '0;
  logic evt_valid, evt_ready = 0;
  logic [AW-1:0] evt_ptr;
  logic [31:0] evt_status, evt_control;
  logic [9:0] evt_intr;

  always #2.5 clk = ~clk;

  cmd_ring_fetch #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .db_ring(db_ring), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_ptr(evt_ptr), .evt_status(evt_status),
    .evt_control(evt_control), .evt_intr(evt_intr)
  );

  int n_chk = 0, n_fail = 0;
  logic [127:0] mem [int unsigned];
  bit bad [int unsigned];
  int unsigned exp_fetch [$];
  logic [41:0] exp_evt [$];
  logic [AW-1:0] exp_ctl;
  bit model_on = 0;
  int ready_mode = 0;
  int tick = 0;
  int fetch_cnt = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input logic [31:0] ptr, input logic [5:0] typ,
                                     input bit cyc, input bit tog, input logic [9:0] intr);
    return {intr, 6'd0, typ, 8'd0, tog, cyc, 32'h5A5A0000, 32'd0, ptr};
  endfunction

  task automatic run_model(input logic [AW-1:0] start);
    int unsigned a;
    bit cyc;
    logic [127:0] w;
    a = start & ~32'h3F;
    cyc = start[0];
    exp_fetch.delete();
    exp_evt.delete();
    for (int k = 0; k < 1000; k++) begin
      exp_fetch.push_back(a);
      if (bad.exists(a)) begin
        exp_ctl = {start[AW-1:1], cyc} | 32'h8;
        return;
      end
      w = mem.exists(a) ? mem[a] : 128'd0;
      if (w[96] != cyc) begin
        exp_ctl = {a[31:6], start[5:4], 1'b0, start[2:1], cyc};
        return;
      end
      exp_evt.push_back({w[127:118], a});
      if (w[111:106] == 6'd6) begin
        if (w[97]) cyc = ~cyc;
        a = w[31:0] & ~32'h3F;
      end else begin
        a = a + 16;
      end
    end
  endtask

  always @(negedge clk) begin
    tick++;
    if (mem_valid) begin
      mem_valid = 0;
      mem_err = 0;
    end else if (mem_req) begin
      fetch_cnt++;
      if (model_on) begin
        if (exp_fetch.size() == 0) check("R2/R8 unexpected read", 64'(mem_addr), 64'hFFFF_FFFF_FFFF_FFFF);
        else check("R8 read address", 64'(mem_addr), 64'(exp_fetch.pop_front()));
      end
      mem_err = bad.exists(mem_addr);
      mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 128'd0;
      mem_valid = 1;
    end
  end

  always @(negedge clk) begin
    logic nr;
    nr = (ready_mode == 0) ? 1'b1 : (tick % 3 == 2);
    if (evt_valid && nr && model_on) begin
      if (exp_evt.size() == 0) begin
        check("R6 unexpected event", 64'(evt_ptr), 64'hFFFF_FFFF_FFFF_FFFF);
      end else begin
        logic [41:0] e;
        e = exp_evt.pop_front();
        check("R6 evt_ptr", 64'(evt_ptr), 64'(e[31:0]));
        check("R4 evt_intr", 64'(evt_intr), 64'(e[41:32]));
        check("R6 evt_status", 64'(evt_status), 64'h0100_0000);
        check("R6 evt_control", 64'(evt_control), 64'h0000_8401);
      end
    end
    evt_ready = nr;
  end

  task automatic write_ctl(input logic [AW-1:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic ring();
    @(negedge clk); db_ring = 1;
    @(negedge clk); db_ring = 0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run(input string req);
    check({req, " final ctl_q"}, 64'(ctl_q), 64'(exp_ctl));
    check({req, " busy low"}, 64'(busy), 64'd0);
    check("R6 all events seen", 64'(exp_evt.size()), 64'd0);
    check("R8 all reads seen", 64'(exp_fetch.size()), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ctl_q reset", 64'(ctl_q), 64'd0);
    check("R1 busy reset", 64'(busy), 64'd0);
    check("R1 mem_req reset", 64'(mem_req), 64'd0);
    check("R1 evt_valid reset", 64'(evt_valid), 64'd0);
    rst_n = 1;

    // R2 R4 R5 R6: straight ring, stops on mismatch
    mem.delete(); bad.delete();
    mem[32'h1000] = mk(32'h0, 6'd9, 1, 0, 10'd1);
    mem[32'h1010] = mk(32'h0, 6'd11, 1, 0, 10'h2AA);
    mem[32'h1020] = mk(32'h0, 6'd23, 1, 1, 10'd0);
    mem[32'h1030] = mk(32'h0, 6'd9, 0, 0, 10'd7);
    write_ctl(32'h1011);
    check("R12 idle load", 64'(ctl_q), 64'h1011);
    run_model(32'h1011);
    model_on = 1; fetch_cnt = 0;
    ring();
    @(negedge clk);
    check("R2 running flag set", 64'(ctl_q[3]), 64'd1);
    wait_idle();
    finish_run("R5");

    // R7 R8 R9: link with toggle, backpressure
    mem.delete();
    mem[32'h2040] = mk(32'h0, 6'd9, 0, 0, 10'd5);
    mem[32'h2050] = mk(32'h3007, 6'd6, 0, 1, 10'd3);
    mem[32'h3000] = mk(32'h0, 6'd9, 1, 0, 10'h3FF);
    mem[32'h3010] = mk(32'h0, 6'd9, 0, 0, 10'd0);
    ready_mode = 1;
    write_ctl(32'h2040);
    run_model(32'h2040);
    ring();
    wait_idle();
    finish_run("R9");
    check("R9 cycle bit toggled", 64'(ctl_q[0]), 64'd1);

    // R3 R12: link without toggle, doorbell and write while busy
    mem.delete();
    mem[32'h4000] = mk(32'h4100, 6'd6, 1, 0, 10'd9);
    mem[32'h4100] = mk(32'h0, 6'd9, 1, 0, 10'd4);
    mem[32'h4110] = mk(32'h0, 6'd9, 1, 0, 10'd8);
    mem[32'h4120] = mk(32'h0, 6'd9, 0, 0, 10'd0);
    ready_mode = 1;
    write_ctl(32'h4001);
    run_model(32'h4001);
    fetch_cnt = 0;
    ring();
    @(negedge clk); db_ring = 1; ctl_wr = 1; ctl_wdata = 32'hDEAD_0000;
    @(negedge clk); db_ring = 0; ctl_wr = 0;
    @(negedge clk); db_ring = 1;
    @(negedge clk); db_ring = 0;
    wait_idle();
    finish_run("R12");
    check("R3 read count", 64'(fetch_cnt), 64'd4);

    // R10: read error
    mem.delete(); bad.delete();
    mem[32'h6000] = mk(32'h0, 6'd9, 1, 0, 10'd2);
    bad[32'h6010] = 1;
    ready_mode = 0;
    write_ctl(32'h6001);
    run_model(32'h6001);
    ring();
    wait_idle();
    finish_run("R10");
    check("R10 ctl_q kept", 64'(ctl_q), 64'h6009);

    // R11: controller clear mid-run
    mem.delete(); bad.delete();
    for (int i = 0; i < 8; i++) mem[32'h5000 + 16*i] = mk(32'h0, 6'd9, 1, 0, 10'(i));
    model_on = 0;
    write_ctl(32'h5001);
    ring();
    repeat (7) @(negedge clk);
    ctl_clear = 1;
    @(negedge clk); ctl_clear = 0;
    check("R11 ctl_q cleared", 64'(ctl_q), 64'd0);
    check("R11 busy cleared", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    check("R11 no activity", 64'({mem_req, evt_valid}), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule